// File: doc/BRIEF.md
# SPI Pause Front End

This block stands between the pins of an SPI target and its serial engine and implements the pause function of the hold input. All pin inputs are brought into the system clock domain, and serial clock edges are turned into single-cycle rise and fall strobes for the engine. While the target is selected and the pause is active, the engine sees no clock strobes and a frozen data input. The bit sequence therefore resumes exactly where it stopped. The serial output is disabled whenever the hold input is low.

Entering and leaving the pause depends on the level of the serial clock. A pause asked for while the clock is low takes effect at once. A pause asked for while the clock is high waits for the next falling edge, and that edge is still delivered to the engine. Release is accepted only on a rising hold edge seen while the clock is low. Deselecting the target drops any pause along with the serial sequence. Command decoding belongs to the engine.

Top module: `spi_hold_frontend`

## Requirements
- R1: While selected and not paused, every synchronized low-to-high clock transition gives exactly one `core_sck_rise` pulse, and every high-to-low transition gives exactly one `core_sck_fall` pulse, each one system clock wide.
- R2: While not paused, `core_sdi` follows the synchronized data input pin.
- R3: Hold going low while the serial clock is low, with the target selected, pauses at once. While paused, no strobes are produced and `core_sdi` keeps the value it had on the last cycle before the pause.
- R4: Hold going low while the serial clock is high defers the pause. Strobes keep flowing, including the next falling-edge strobe, and the pause starts right after that falling edge.
- R5: If hold returns high before a deferred pause has taken effect, the request is dropped and no pause happens.
- R6: A pause ends only when hold makes a low-to-high transition while the serial clock is low. A rise seen while the clock is high is ignored, and the pause lasts until hold goes low and high again with the clock low.
- R7: `pin_sdo_en` equals `core_sdo_en` only while the target is selected, hold is high and no pause is active; otherwise it is 0. `pin_sdo` carries `core_sdo` when enabled and the idle level 0 otherwise.
- R8: While the chip-select pin is high, no strobes are produced and any pause, active or pending, is cleared. After reselection, no release edge is needed.
- R9: During reset, `core_sel_n` is 1, both strobes are 0 and `pin_sdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_pin | input | 1 | Chip-select pin, active low |
| sck_pin | input | 1 | Serial clock pin |
| sdi_pin | input | 1 | Serial data input pin |
| hold_n_pin | input | 1 | Hold pin, active low |
| core_sdo | input | 1 | Output bit from the serial engine |
| core_sdo_en | input | 1 | Output enable requested by the engine |
| core_sel_n | output | 1 | Synchronized chip select for the engine |
| core_sck_rise | output | 1 | Rising-edge strobe to the engine |
| core_sck_fall | output | 1 | Falling-edge strobe to the engine |
| core_sdi | output | 1 | Data input to the engine, frozen during a pause |
| pin_sdo | output | 1 | Data for the output pad |
| pin_sdo_en | output | 1 | Enable for the output pad |

## Verification
The bench targets the clock-level qualification of hold. If a design paused as soon as hold dropped with the clock high, it would swallow the falling-edge strobe that should still reach the engine. If it accepted a release while the clock was high, it would resume with one edge too many. The bench also drops a deferred request before the falling edge arrives: a design that ignored the cancel would stop counting edges. Deselecting during a pause shows whether the pause clears, and changing the data pin while paused shows whether the engine's input is really frozen.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

   typedef enum logic [1:0] {
      HS_RUN  = 2'd0,
      HS_PEND = 2'd1,
      HS_HELD = 2'd2
   } hold_state_e;

   localparam int unsigned PIN_CS   = 0;
   localparam int unsigned PIN_SCK  = 1;
   localparam int unsigned PIN_SDI  = 2;
   localparam int unsigned PIN_HOLD = 3;
   localparam int unsigned PIN_NUM  = 4;

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
   parameter int unsigned        WIDTH   = 4,
   parameter int unsigned        STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
         $error("spi_hold_sync: STAGES must lie in 2..4");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("spi_hold_sync: WIDTH must be at least 1");
      end
   endgenerate

   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d[b]};
         end
         assign q[b] = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_s,
   input  logic hold_n_s,
   output logic sck_rise,
   output logic sck_fall,
   output logic hold_rise
);

   logic sck_q;
   logic hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q  <= 1'b0;
         hold_q <= 1'b1;
      end else begin
         sck_q  <= sck_s;
         hold_q <= hold_n_s;
      end
   end

   assign sck_rise  = sck_s & ~sck_q;
   assign sck_fall  = ~sck_s & sck_q;
   assign hold_rise = hold_n_s & ~hold_q;

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
   import spi_hold_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_s,
   input  logic sck_s,
   input  logic hold_n_s,
   input  logic hold_rise,
   output logic held
);

   hold_state_e state_q;
   hold_state_e state_d;

   always_comb begin
      state_d = state_q;
      if (cs_n_s) begin
         state_d = HS_RUN;
      end else begin
         unique case (state_q)
            HS_RUN: begin
               if (!hold_n_s) state_d = sck_s ? HS_PEND : HS_HELD;
            end
            HS_PEND: begin
               if (hold_n_s)   state_d = HS_RUN;
               else if (!sck_s) state_d = HS_HELD;
            end
            HS_HELD: begin
               if (hold_rise && !sck_s) state_d = HS_RUN;
            end
            default: state_d = HS_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= HS_RUN;
      else        state_q <= state_d;
   end

   assign held = (state_q == HS_HELD);

   // R8: one cycle after a deselected sample no pause is active
   p_desel_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_n_s) |-> !held);

   // R3: a pause only begins after hold was seen low
   p_enter_needs_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(held) |-> $past(!hold_n_s));

   // R6: leaving a pause while selected needs hold high with the clock low
   p_release_low_sck_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(held) && !$past(cs_n_s)) |-> ($past(!sck_s) && $past(hold_n_s)));

endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
   import spi_hold_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SDO_IDLE    = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_pin,
   input  logic sck_pin,
   input  logic sdi_pin,
   input  logic hold_n_pin,
   input  logic core_sdo,
   input  logic core_sdo_en,
   output logic core_sel_n,
   output logic core_sck_rise,
   output logic core_sck_fall,
   output logic core_sdi,
   output logic pin_sdo,
   output logic pin_sdo_en
);

   localparam logic [PIN_NUM-1:0] PIN_RST =
      (1 << PIN_CS) | (1 << PIN_HOLD);

   logic [PIN_NUM-1:0] pins_raw;
   logic [PIN_NUM-1:0] pins_s;
   logic cs_n_s, sck_s, sdi_s, hold_n_s;
   logic sck_rise, sck_fall, hold_rise;
   logic held;
   logic live;
   logic sdi_keep;

   always_comb begin
      pins_raw           = '0;
      pins_raw[PIN_CS]   = cs_n_pin;
      pins_raw[PIN_SCK]  = sck_pin;
      pins_raw[PIN_SDI]  = sdi_pin;
      pins_raw[PIN_HOLD] = hold_n_pin;
   end

   spi_hold_sync #(
      .WIDTH   (PIN_NUM),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   assign cs_n_s   = pins_s[PIN_CS];
   assign sck_s    = pins_s[PIN_SCK];
   assign sdi_s    = pins_s[PIN_SDI];
   assign hold_n_s = pins_s[PIN_HOLD];

   spi_hold_edge u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_s     (sck_s),
      .hold_n_s  (hold_n_s),
      .sck_rise  (sck_rise),
      .sck_fall  (sck_fall),
      .hold_rise (hold_rise)
   );

   spi_hold_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_s    (cs_n_s),
      .sck_s     (sck_s),
      .hold_n_s  (hold_n_s),
      .hold_rise (hold_rise),
      .held      (held)
   );

   assign live          = ~cs_n_s & ~held;
   assign core_sel_n    = cs_n_s;
   assign core_sck_rise = sck_rise & live;
   assign core_sck_fall = sck_fall & live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sdi_keep <= 1'b0;
      else if (!held) sdi_keep <= sdi_s;
   end

   assign core_sdi   = held ? sdi_keep : sdi_s;
   assign pin_sdo_en = core_sdo_en & live & hold_n_s;

   generate
      if (SDO_IDLE) begin : g_idle_high
         assign pin_sdo = pin_sdo_en ? core_sdo : 1'b1;
      end else begin : g_idle_low
         assign pin_sdo = pin_sdo_en ? core_sdo : 1'b0;
      end
   endgenerate

   // R3: the engine's data input stays put across consecutive paused cycles
   p_freeze_sdi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (held && $past(held)) |-> $stable(core_sdi));

   // R7: a paused target never drives the output pad
   p_so_off_paused_r7: assert property (@(posedge clk) disable iff (!rst_n)
      held |-> !pin_sdo_en);

   // R1: a strobe to the engine never fires during a pause
   p_no_strobe_paused_r1: assert property (@(posedge clk) disable iff (!rst_n)
      held |-> !(core_sck_rise || core_sck_fall));

endmodule

// File: tb/tb_spi_hold_frontend.sv
module tb_spi_hold_frontend;

   logic clk = 1'b0;
   logic rst_n;
   logic cs_n_pin, sck_pin, sdi_pin, hold_n_pin, core_sdo, core_sdo_en;
   logic core_sel_n, core_sck_rise, core_sck_fall, core_sdi, pin_sdo, pin_sdo_en;

   int checks = 0;
   int failures = 0;
   int n_rise = 0;
   int n_fall = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   spi_hold_frontend dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cs_n_pin      (cs_n_pin),
      .sck_pin       (sck_pin),
      .sdi_pin       (sdi_pin),
      .hold_n_pin    (hold_n_pin),
      .core_sdo      (core_sdo),
      .core_sdo_en   (core_sdo_en),
      .core_sel_n    (core_sel_n),
      .core_sck_rise (core_sck_rise),
      .core_sck_fall (core_sck_fall),
      .core_sdi      (core_sdi),
      .pin_sdo       (pin_sdo),
      .pin_sdo_en    (pin_sdo_en)
   );

   always @(posedge clk) begin
      if (core_sck_rise) n_rise <= n_rise + 1;
      if (core_sck_fall) n_fall <= n_fall + 1;
   end

   // {cs_n, sck, sdi, hold_n} | exp sdi | exp en | rise | fall | req
   localparam logic [17:0] VEC [0:25] = '{
      {4'b1001, 1'b0, 1'b0, 4'd0, 4'd0, 4'd8},
      {4'b0011, 1'b1, 1'b1, 4'd0, 4'd0, 4'd2},
      {4'b0111, 1'b1, 1'b1, 4'd1, 4'd0, 4'd1},
      {4'b0011, 1'b1, 1'b1, 4'd1, 4'd1, 4'd1},
      {4'b0010, 1'b1, 1'b0, 4'd1, 4'd1, 4'd3},
      {4'b0000, 1'b1, 1'b0, 4'd1, 4'd1, 4'd3},
      {4'b0100, 1'b1, 1'b0, 4'd1, 4'd1, 4'd3},
      {4'b0000, 1'b1, 1'b0, 4'd1, 4'd1, 4'd3},
      {4'b0100, 1'b1, 1'b0, 4'd1, 4'd1, 4'd3},
      {4'b0101, 1'b1, 1'b0, 4'd1, 4'd1, 4'd6},
      {4'b0001, 1'b1, 1'b0, 4'd1, 4'd1, 4'd6},
      {4'b0000, 1'b1, 1'b0, 4'd1, 4'd1, 4'd6},
      {4'b0001, 1'b0, 1'b1, 4'd1, 4'd1, 4'd6},
      {4'b0101, 1'b0, 1'b1, 4'd2, 4'd1, 4'd1},
      {4'b0100, 1'b0, 1'b0, 4'd2, 4'd1, 4'd4},
      {4'b0000, 1'b0, 1'b0, 4'd2, 4'd2, 4'd4},
      {4'b0110, 1'b0, 1'b0, 4'd2, 4'd2, 4'd4},
      {4'b0010, 1'b0, 1'b0, 4'd2, 4'd2, 4'd3},
      {4'b1010, 1'b1, 1'b0, 4'd2, 4'd2, 4'd8},
      {4'b1011, 1'b1, 1'b0, 4'd2, 4'd2, 4'd8},
      {4'b0011, 1'b1, 1'b1, 4'd2, 4'd2, 4'd8},
      {4'b0111, 1'b1, 1'b1, 4'd3, 4'd2, 4'd8},
      {4'b0110, 1'b1, 1'b0, 4'd3, 4'd2, 4'd4},
      {4'b0111, 1'b1, 1'b1, 4'd3, 4'd2, 4'd5},
      {4'b0001, 1'b0, 1'b1, 4'd3, 4'd3, 4'd5},
      {4'b0101, 1'b0, 1'b1, 4'd4, 4'd3, 4'd5}
   };

   function automatic string req_name(input logic [3:0] code);
      case (code)
         4'd1: return "R1";
         4'd2: return "R2";
         4'd3: return "R3";
         4'd4: return "R4";
         4'd5: return "R5";
         4'd6: return "R6";
         4'd7: return "R7";
         4'd8: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic settle();
      repeat (6) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pins(input logic [3:0] p);
      {cs_n_pin, sck_pin, sdi_pin, hold_n_pin} = p;
   endtask

   initial begin
      rst_n = 1'b0;
      pins(4'b1001);
      core_sdo = 1'b1;
      core_sdo_en = 1'b1;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9", "core_sel_n", core_sel_n, 1);
      chk("R9", "rise strobe", core_sck_rise, 0);
      chk("R9", "fall strobe", core_sck_fall, 0);
      chk("R9", "pin_sdo_en", pin_sdo_en, 0);
      rst_n = 1'b1;
      settle();

      for (int i = 0; i < 26; i++) begin
         pins(VEC[i][17:14]);
         settle();
         chk(req_name(VEC[i][3:0]), $sformatf("row %0d core_sdi", i), core_sdi, VEC[i][13]);
         chk(req_name(VEC[i][3:0]), $sformatf("row %0d pin_sdo_en", i), pin_sdo_en, VEC[i][12]);
         chk(req_name(VEC[i][3:0]), $sformatf("row %0d rise count", i), n_rise, VEC[i][11:8]);
         chk(req_name(VEC[i][3:0]), $sformatf("row %0d fall count", i), n_fall, VEC[i][7:4]);
      end

      // R7: output gating by the engine enable and by hold
      pins(4'b0001);
      core_sdo_en = 1'b0;
      settle();
      chk("R7", "pad enable with engine enable off", pin_sdo_en, 0);
      chk("R7", "idle pad level", pin_sdo, 0);
      core_sdo_en = 1'b1;
      core_sdo = 1'b1;
      settle();
      chk("R7", "pad data one", pin_sdo, 1);
      core_sdo = 1'b0;
      settle();
      chk("R7", "pad data zero", pin_sdo, 0);
      core_sdo = 1'b1;
      pins(4'b0000);
      settle();
      chk("R7", "pad enable with hold low", pin_sdo_en, 0);
      chk("R7", "pad level with hold low", pin_sdo, 0);
      pins(4'b0001);
      settle();
      chk("R7", "pad enable after release", pin_sdo_en, 1);

      // R8: clock toggles while deselected produce no strobes
      pins(4'b1001);
      settle();
      pins(4'b1101);
      settle();
      pins(4'b1001);
      settle();
      chk("R8", "rise count deselected", n_rise, 4);
      chk("R8", "fall count deselected", n_fall, 4);
      chk("R8", "core_sel_n deselected", core_sel_n, 1);

      // R1: a selected pulse afterwards counts again
      pins(4'b0001);
      settle();
      pins(4'b0101);
      settle();
      pins(4'b0001);
      settle();
      chk("R1", "rise count after reselect", n_rise, 5);
      chk("R1", "fall count after reselect", n_fall, 5);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog all requirements actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule